// File: doc/BRIEF.md
# Pulsed-Select SPI Master

This block is a synchronous SPI master that sends and receives frames of 4 to 16 bits, most significant bit first. The frame length is set by a configuration field. A divider runs from the peripheral clock and sets the SCK rate. The clock polarity and the clock phase can each be selected. Transmit words arrive on a valid/ready handshake. Each received word leaves on a data bus, together with a strobe that lasts one cycle.

When a transmit word is already waiting as a frame ends, the next frame follows at once. In pulse mode the master raises the slave-select line for exactly one SCK period between the two frames. A single attached slave can use that rising edge to latch each word. With pulse mode off, select stays low for the whole burst. When nothing is queued at the end of a frame, select goes high and stays high until the next word is accepted. Configuration is expected to change only while the bus is idle.

Top module: `spi_pulse_master`

## Requirements
- R1: After reset, `nss` is 1, `sck` equals `cfg_cpol`, `rx_valid` is 0 and `tx_ready` is 1.
- R2: Each half-period of SCK inside a frame lasts exactly 2^`cfg_br` peripheral clock cycles, so one SCK period is 2^(`cfg_br`+1) cycles (divisors 2 to 256).
- R3: `cfg_len` holds the frame length minus one, with valid values 3 to 15. Each frame makes exactly `cfg_len`+1 SCK cycles, which is 2×(`cfg_len`+1) edges.
- R4: MOSI carries bits `cfg_len` down to 0 of the accepted word, in that order. Bits of `tx_data` above `cfg_len` have no effect on the line.
- R5: MISO is captured on the sampling edge, most significant bit first. Bit 0 of `rx_data` holds the last bit captured, and bits above `cfg_len` read 0.
- R6: `rx_valid` rises for exactly one cycle per frame, after the frame's last SCK edge has been sampled, and `rx_data` is valid in that cycle.
- R7: Whenever `nss` is high, `sck` rests at the `cfg_cpol` level and makes no edges.
- R8: With `cfg_pulse`=1, a word accepted at the end of a frame starts the next frame after `nss` has been high for exactly 2^(`cfg_br`+1) cycles (one SCK period). No SCK edge occurs during that interval.
- R9: With `cfg_pulse`=0, a word accepted at the end of a frame keeps `nss` low, and the next frame's first bit follows without a gap.
- R10: A word is accepted only while idle or in the last cycle of a frame. If none is offered at a frame end, `nss` goes high and stays high, with `tx_ready` at 1, until the next word is accepted. Accepting a word while idle drives `nss` low in the next cycle.
- R11: With `cfg_cpha`=0, the first bit is on MOSI before the leading edge, sampling happens on leading edges and shifting on trailing edges. With `cfg_cpha`=1, shifting happens on leading edges and sampling on trailing edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_pulse | input | 1 | Raise select for one SCK period between queued frames |
| cfg_br | input | 3 | Divider exponent; SCK period is 2^(cfg_br+1) clocks |
| cfg_len | input | 4 | Frame length minus one (3 to 15) |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken this cycle when valid |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| nss | output | 1 | Active-low slave select |
| miso | input | 1 | Serial data in |

## Verification
The properties assume that the configuration inputs do not change while `nss` is low or a select pulse is under way. They also assume that `tx_valid`, once raised, stays up until the handshake. The stimulus changes every configuration field only while the master is idle with select high. It holds each word on `tx_data` from one falling clock edge until the cycle after `tx_ready` was seen, and it presents each following word of a burst long before the current frame ends. The slave model in the bench changes MISO only on shifting edges, so the value the master captures was settled half an SCK period earlier.

// File: rtl/spi_pulse_master.sv
module spi_pulse_master #(
  parameter int DW  = 16,
  parameter int BRW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_cpol,
  input  logic                    cfg_cpha,
  input  logic                    cfg_pulse,
  input  logic [BRW-1:0]          cfg_br,
  input  logic [$clog2(DW)-1:0]   cfg_len,
  input  logic [DW-1:0]           tx_data,
  input  logic                    tx_valid,
  output logic                    tx_ready,
  output logic [DW-1:0]           rx_data,
  output logic                    rx_valid,
  output logic                    sck,
  output logic                    mosi,
  output logic                    nss,
  input  logic                    miso
);
  localparam int LW   = $clog2(DW);
  localparam int HW   = LW + 1;
  localparam int DIVW = 1 << BRW;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;

  st_t             st;
  logic [DIVW-1:0] div;
  logic [HW-1:0]   h;
  logic [DW-1:0]   sh, rs;
  logic [DIVW-1:0] half_m1;
  logic            tick, frame_end, take;

  assign half_m1   = (DIVW'(1) << cfg_br) - DIVW'(1);
  assign tick      = (div == half_m1);
  assign frame_end = (st == S_RUN) && tick && (h == {cfg_len, 1'b1});
  assign tx_ready  = (st == S_IDLE) || frame_end;
  assign take      = tx_valid && tx_ready;

  assign sck  = (st == S_RUN) ? (cfg_cpol ^ cfg_cpha ^ h[0]) : cfg_cpol;
  assign nss  = (st != S_RUN);
  assign mosi = sh[cfg_len];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      div      <= '0;
      h        <= '0;
      sh       <= '0;
      rs       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          div <= '0;
          h   <= '0;
          if (take) begin
            st <= S_RUN;
            sh <= tx_data;
            rs <= '0;
          end
        end
        S_RUN: begin
          if (tick) begin
            div <= '0;
            if (frame_end) begin
              rx_valid <= 1'b1;
              rx_data  <= rs;
              h        <= '0;
              if (take) begin
                sh <= tx_data;
                rs <= '0;
                st <= cfg_pulse ? S_GAP : S_RUN;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              h <= h + HW'(1);
              if (!h[0]) rs <= {rs[DW-2:0], miso};
              else       sh <= sh << 1;
            end
          end else begin
            div <= div + DIVW'(1);
          end
        end
        S_GAP: begin
          if (tick) begin
            div <= '0;
            if (h[0]) begin
              st <= S_RUN;
              h  <= '0;
            end else begin
              h <= h + HW'(1);
            end
          end else begin
            div <= div + DIVW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module spi_pulse_master_sva (
  input logic clk,
  input logic rst_n,
  input logic cfg_cpol,
  input logic cfg_pulse,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic sck,
  input logic nss
);
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    nss |-> (sck == cfg_cpol));

  a_r10_start_select: assert property (@(posedge clk) disable iff (!rst_n)
    (nss && tx_valid && tx_ready) |=> !nss);

  a_r9_stream_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!nss && !cfg_pulse && tx_valid && tx_ready) |=> !nss);

  a_r8_pulse_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!nss && cfg_pulse && tx_valid && tx_ready) |=> nss ##1 nss);

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(!nss));
endmodule

bind spi_pulse_master spi_pulse_master_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_pulse(cfg_pulse),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .sck(sck), .nss(nss)
);

// File: tb/spi_pulse_master_test.sv
module spi_pulse_master_test;
  localparam int CLK = 10;

  logic clk = 0, rst_n = 0;
  logic cpol = 0, cpha = 0, pulse = 0;
  logic [2:0]  br = 0;
  logic [3:0]  len = 7;
  logic [15:0] tx_data = 0;
  logic        tx_valid = 0;
  logic        miso = 0;
  wire  [15:0] rx_data;
  wire         tx_ready, rx_valid, sck, mosi, nss;

  spi_pulse_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_pulse(pulse),
    .cfg_br(br), .cfg_len(len), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .sck(sck), .mosi(mosi), .nss(nss), .miso(miso)
  );

  always #(CLK/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] exp_tx_q[$], reply_q[$], exp_rx_q[$];
  int gaps[$];

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] fmask();
    return 16'((32'd1 << (int'(len) + 1)) - 1);
  endfunction

  // slave model
  logic [15:0] cur = 0, srx = 0;
  int idx = 0, samples = 0;

  task automatic load_word();
    cur = (reply_q.size() > 0) ? reply_q.pop_front() : 16'h0;
    idx = int'(len);
    miso = cur[idx];
    idx--;
  endtask

  always @(negedge nss) begin
    #1;
    if (rst_n && nss === 1'b0) begin
      samples = 0;
      srx = 0;
      if (!cpha) load_word();
    end
  end

  always @(sck) begin
    #1;
    if (rst_n && nss === 1'b0) begin
      if (sck == (cpol ^ !cpha)) begin
        srx = {srx[14:0], mosi};
        samples++;
        if (samples == int'(len) + 1) begin
          logic [15:0] e;
          e = (exp_tx_q.size() > 0) ? exp_tx_q.pop_front() : 16'hxxxx;
          chk(srx === e, "R4/R11 mosi word", srx, e);
          samples = 0;
          srx = 0;
        end
      end else begin
        if (samples == 0) load_word();
        else if (idx >= 0) begin
          miso = cur[idx];
          idx--;
        end
      end
    end
  end

  // monitor
  logic prev_sck = 0, prev_nss = 1, prev_rxv = 0, run_valid = 0;
  int hi_run = 0, edges = 0, srun = 0, rmin = 1 << 30, rmax = 0, idle_viol = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        logic [15:0] e;
        e = (exp_rx_q.size() > 0) ? exp_rx_q.pop_front() : 16'hxxxx;
        chk(rx_data === e, "R5 rx word", rx_data, e);
        chk(!prev_rxv, "R6 strobe width", prev_rxv, 0);
      end
      if (nss && sck !== cpol) idle_viol++;
      if (nss) hi_run++;
      else if (prev_nss) begin gaps.push_back(hi_run); hi_run = 0; end
      if (sck != prev_sck && (!nss || !prev_nss)) edges++;
      if (sck != prev_sck) begin
        if (run_valid) begin
          if (srun < rmin) rmin = srun;
          if (srun > rmax) rmax = srun;
        end
        srun = 1;
        run_valid = !nss;
      end else if (!nss && prev_nss) begin
        srun = 1;
        run_valid = 1;
      end else if (nss) begin
        run_valid = 0;
      end else begin
        srun++;
      end
    end
    prev_sck = sck;
    prev_nss = nss;
    prev_rxv = rx_valid;
  end

  task automatic burst(int n, int l, bit pol, bit pha, bit pul, int b, logic [15:0] seed);
    int half;
    @(negedge clk);
    cpol = pol; cpha = pha; pulse = pul; br = 3'(b); len = 4'(l);
    half = 1 << b;
    @(negedge clk);
    gaps.delete();
    edges = 0; rmin = 1 << 30; rmax = 0; idle_viol = 0;
    for (int k = 0; k < n; k++) begin
      logic [15:0] w, r;
      w = seed ^ 16'(16'h9E37 * (k + 1));
      r = ~w ^ 16'h3C5A;
      exp_tx_q.push_back(w & fmask());
      reply_q.push_back(r);
      exp_rx_q.push_back(r & fmask());
      if (k > 0) @(negedge clk);
      tx_valid = 1;
      tx_data = w;
      while (!tx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    tx_valid = 0;
    tx_data = 16'hDEAD;
    while (exp_rx_q.size() > 0) @(negedge clk);
    repeat (4 * half + 4) @(negedge clk);
    chk(nss == 1'b1, "R10 select high after burst", nss, 1);
    chk(tx_ready == 1'b1, "R10 ready while idle", tx_ready, 1);
    chk(exp_tx_q.size() == 0, "R4 all words seen by slave", exp_tx_q.size(), 0);
    chk(edges == 2 * (l + 1) * n, "R3 sck edge count", edges, 2 * (l + 1) * n);
    chk(rmin == half && rmax == half, "R2 half period", rmax, half);
    chk(idle_viol == 0, "R7 sck idle level", idle_viol, 0);
    if (gaps.size() > 0) void'(gaps.pop_front());
    if (pul) begin
      chk(gaps.size() == n - 1, "R8 pulse count", gaps.size(), n - 1);
      foreach (gaps[i]) chk(gaps[i] == 2 * half, "R8 pulse width", gaps[i], 2 * half);
    end else begin
      chk(gaps.size() == 0, "R9 select stays low", gaps.size(), 0);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(nss == 1'b1, "R1 nss reset", nss, 1);
    chk(sck == 1'b0, "R1 sck reset", sck, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid reset", rx_valid, 0);
    chk(tx_ready == 1'b1, "R1 tx_ready reset", tx_ready, 1);
    cpol = 1;
    @(negedge clk);
    chk(sck == 1'b1, "R7 idle follows polarity", sck, 1);

    burst(4, 7,  0, 0, 1, 0, 16'hA5C3);
    burst(3, 15, 1, 0, 1, 2, 16'h1234);
    burst(3, 3,  0, 0, 0, 1, 16'hFFF0);
    burst(3, 11, 1, 1, 0, 0, 16'h0F0F);
    burst(2, 9,  0, 1, 0, 3, 16'hBEEF);
    burst(2, 5,  1, 1, 1, 1, 16'h7777);
    burst(1, 7,  1, 0, 1, 7, 16'h5AA5);
    finish_run();
  end
endmodule